// File: doc/BRIEF.md
# Host Write Repacker for a 24-bit Core Receive Queue

This block sits between a host bus write port and the receive queue that a 24-bit processor core reads. Each accepted host write is repacked into one or two 24-bit core words and pushed into a small on-block FIFO. The core drains that FIFO through a pop port.

Two bus types are supported. A 32-bit PCI-style bus can split each write into two halfword-carrying core words, or it can pick one 24-bit byte window out of the 32-bit word. A generic parallel bus carries 24-bit or 16-bit data. The 16-bit data can be placed right-aligned with zero or sign fill, or left-aligned with a zero low byte.

A 2-bit format code selects the packing. A format change is requested on a strobe and held pending. It takes effect only once the FIFO is empty. If the change enters or leaves the two-word split packing, it also waits for the idle-mode input. When the change is applied, a one-cycle flag is raised. The FIFO depth is a parameter and must be a power of two, at least 2.

Top module: `hostFmtConv`

## Requirements
- R1: With busMode=0 (PCI-style) and format code 0, one accepted write pushes two words in order. The first word is {8'h00, data[15:0]} and the second is {8'h00, data[31:16]}.
- R2: With busMode=0 and format code 1 or 2, one accepted write pushes one word equal to data[23:0].
- R3: With busMode=0 and format code 3, one accepted write pushes one word equal to data[31:8].
- R4: With busMode=1 (generic) and format code 0, one accepted write pushes data[23:0] unchanged.
- R5: With busMode=1 and format code 1, the pushed word is {8'h00, data[15:0]}.
- R6: With busMode=1 and format code 2, the pushed word is data[15:0] sign-extended from bit 15 to 24 bits.
- R7: With busMode=1 and format code 3, the pushed word is {data[15:0], 8'h00}.
- R8: After reset the format code is 0, the FIFO is empty (popValid=0), fmtApplied=0 and hostWrReady=1.
- R9: hostWrReady is low whenever an accepted write would not fit. A split write (busMode=0, code 0) needs two free entries. Any other write needs one. A pop in the same cycle does not count as freeing space.
- R10: Words leave the FIFO in push order. popValid is high exactly when the FIFO holds a word. popData shows the oldest word. A pop request on an empty FIFO has no effect.
- R11: A format request is latched on the edge where fmtReqValid is high. When the FIFO is empty and no idle wait applies, the following cycle is the apply cycle: hostWrReady is low, and at its closing edge fmtCur takes the new code and fmtApplied pulses high for one cycle. While the FIFO holds data, the old code stays in force.
- R12: With busMode=0, a pending change from code 0 to a non-zero code, or the reverse, is applied only while idleMode is high (and the FIFO is empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMode | input | 1 | 0 = 32-bit PCI-style bus, 1 = generic 24/16-bit bus |
| idleMode | input | 1 | Interface held idle; permits entering or leaving split packing |
| fmtReqValid | input | 1 | Format change request strobe |
| fmtReq | input | 2 | Requested format code |
| fmtCur | output | 2 | Format code in force |
| fmtApplied | output | 1 | One-cycle pulse when a requested code takes effect |
| hostWrValid | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data |
| hostWrReady | output | 1 | Host write can be accepted this cycle |
| popReq | input | 1 | Core pop request |
| popData | output | 24 | Oldest queued core word |
| popValid | output | 1 | FIFO holds at least one word |

## Verification
The bench sweeps every bus mode and format code over data chosen to expose bad extension and lane selection. The data patterns include bit 15 set and clear, and distinct bytes in every lane. A swapped lane, wrong fill or missing second half therefore shows up as a wrong popped word.

The bench fills the FIFO to one free entry while in split packing and expects back-pressure. A design that counts free space one short would split a pair around the wrap or overflow.

Format requests are issued with data still queued, and a split-crossing request is issued with idleMode low. A design that applied them early would repack the queued word or change code before idle mode was asserted. A design that mistimed the apply cycle would show the wrong code or flag in the exact cycle the bench samples.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  localparam int HOST_W = 32;
  localparam int CORE_W = 24;
  localparam int HALF_W = 16;
  localparam int FMT_W  = 2;

  localparam logic BUS_PCI     = 1'b0;
  localparam logic BUS_GENERIC = 1'b1;

  typedef struct packed {
    logic push1;
    logic push2;
    logic pop;
  } hfcStrobes_t;
endpackage

// File: rtl/hfc_ctrl.sv
module hfc_ctrl
  import hfc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busMode,
  input  logic             idleMode,
  input  logic             fmtReqValid,
  input  logic [FMT_W-1:0] fmtReq,
  input  logic             hostWrValid,
  input  logic             popReq,
  input  logic [CW-1:0]    fillLevel,
  output logic [FMT_W-1:0] fmtCur,
  output logic             fmtApplied,
  output logic             hostWrReady,
  output logic             splitMode,
  output hfcStrobes_t      strobes
);
  logic             pendValid;
  logic [FMT_W-1:0] pendFmt;
  logic [CW-1:0]    freeSlots;
  logic             haveSpace;
  logic             crossing;
  logic             applyNow;
  logic             accept;

  always_comb begin
    splitMode   = (busMode == BUS_PCI) && (fmtCur == '0);
    freeSlots   = CW'(DEPTH) - fillLevel;
    haveSpace   = splitMode ? (freeSlots >= CW'(2)) : (freeSlots >= CW'(1));
    crossing    = (busMode == BUS_PCI) && ((fmtCur == '0) != (pendFmt == '0));
    applyNow    = pendValid && (fillLevel == '0) && (!crossing || idleMode);
    hostWrReady = haveSpace && !applyNow;
    accept      = hostWrValid && hostWrReady;
    strobes.push1 = accept;
    strobes.push2 = accept && splitMode;
    strobes.pop   = popReq && (fillLevel != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendFmt    <= '0;
      fmtCur     <= '0;
      fmtApplied <= 1'b0;
    end else begin
      fmtApplied <= applyNow;
      if (applyNow) fmtCur <= pendFmt;
      if (fmtReqValid) begin
        pendValid <= 1'b1;
        pendFmt   <= fmtReq;
      end else if (applyNow) begin
        pendValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hfc_datapath.sv
module hfc_datapath
  import hfc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  logic [FMT_W-1:0]  fmtCur,
  input  logic [HOST_W-1:0] hostWrData,
  input  hfcStrobes_t       strobes,
  output logic [CW-1:0]     fillLevel,
  output logic [CORE_W-1:0] popData
);
  localparam int PAD_W = CORE_W - HALF_W;

  logic [CORE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wrPtr;
  logic [PW-1:0]     rdPtr;
  logic [CORE_W-1:0] word0;
  logic [CORE_W-1:0] word1;
  logic [HALF_W-1:0] lowHalf;

  always_comb begin
    lowHalf = hostWrData[HALF_W-1:0];
    word1   = {{PAD_W{1'b0}}, hostWrData[HOST_W-1:HALF_W]};
    if (busMode == BUS_PCI) begin
      unique case (fmtCur)
        2'd0:    word0 = {{PAD_W{1'b0}}, lowHalf};
        2'd3:    word0 = hostWrData[HOST_W-1:HOST_W-CORE_W];
        default: word0 = hostWrData[CORE_W-1:0];
      endcase
    end else begin
      unique case (fmtCur)
        2'd0:    word0 = hostWrData[CORE_W-1:0];
        2'd1:    word0 = {{PAD_W{1'b0}}, lowHalf};
        2'd2:    word0 = {{PAD_W{lowHalf[HALF_W-1]}}, lowHalf};
        default: word0 = {lowHalf, {PAD_W{1'b0}}};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push1) mem[wrPtr] <= word0;
    if (strobes.push2) mem[wrPtr + PW'(1)] <= word1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
    end else begin
      if (strobes.push1) wrPtr <= wrPtr + PW'(1) + PW'(strobes.push2);
      if (strobes.pop)   rdPtr <= rdPtr + PW'(1);
      fillLevel <= fillLevel + CW'(strobes.push1) + CW'(strobes.push2)
                 - CW'(strobes.pop);
    end
  end

  assign popData = mem[rdPtr];
endmodule

// File: rtl/hostFmtConv.sv
module hostFmtConv
  import hfc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  logic              idleMode,
  input  logic              fmtReqValid,
  input  logic [FMT_W-1:0]  fmtReq,
  output logic [FMT_W-1:0]  fmtCur,
  output logic              fmtApplied,
  input  logic              hostWrValid,
  input  logic [HOST_W-1:0] hostWrData,
  output logic              hostWrReady,
  input  logic              popReq,
  output logic [CORE_W-1:0] popData,
  output logic              popValid
);
  localparam int CW = $clog2(DEPTH + 1);

  hfcStrobes_t   strobes;
  logic [CW-1:0] fillLevel;
  logic          splitMode;

  hfc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busMode(busMode), .idleMode(idleMode),
    .fmtReqValid(fmtReqValid), .fmtReq(fmtReq), .hostWrValid(hostWrValid),
    .popReq(popReq), .fillLevel(fillLevel), .fmtCur(fmtCur),
    .fmtApplied(fmtApplied), .hostWrReady(hostWrReady),
    .splitMode(splitMode), .strobes(strobes)
  );

  hfc_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .busMode(busMode), .fmtCur(fmtCur),
    .hostWrData(hostWrData), .strobes(strobes), .fillLevel(fillLevel),
    .popData(popData)
  );

  assign popValid = (fillLevel != '0);
endmodule

// File: rtl/hostFmtConv_chk.sv
module hostFmtConv_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          busMode,
  input logic          idleMode,
  input logic [1:0]    fmtCur,
  input logic          fmtApplied,
  input logic          hostWrValid,
  input logic          hostWrReady,
  input logic          popValid,
  input logic [CW-1:0] fillLevel
);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CW'(DEPTH));

  assert_split_room_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrValid && hostWrReady && !busMode && fmtCur == 2'd0)
      |-> (fillLevel <= CW'(DEPTH - 2)));

  assert_code_change_flagged_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fmtCur) |-> fmtApplied);

  assert_apply_on_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    fmtApplied |-> $past(!popValid));

  assert_cross_needs_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    (fmtApplied && !busMode && ((fmtCur == 2'd0) != ($past(fmtCur) == 2'd0)))
      |-> $past(idleMode));
endmodule

bind hostFmtConv hostFmtConv_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busMode(busMode), .idleMode(idleMode),
  .fmtCur(fmtCur), .fmtApplied(fmtApplied), .hostWrValid(hostWrValid),
  .hostWrReady(hostWrReady), .popValid(popValid), .fillLevel(fillLevel)
);

// File: tb/hostFmtConv_tb.sv
`timescale 1ns/1ps
module hostFmtConv_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busMode = 1'b0;
  logic        idleMode = 1'b0;
  logic        fmtReqValid = 1'b0;
  logic [1:0]  fmtReq = 2'd0;
  logic [1:0]  fmtCur;
  logic        fmtApplied;
  logic        hostWrValid = 1'b0;
  logic [31:0] hostWrData = '0;
  logic        hostWrReady;
  logic        popReq = 1'b0;
  logic [23:0] popData;
  logic        popValid;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hostFmtConv #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expWords(input logic bm, input logic [1:0] f, input logic [31:0] d,
                          output int n, output logic [23:0] w0, output logic [23:0] w1);
    longint lo;
    lo = longint'(d) % 65536;
    n  = 1;
    w1 = '0;
    if (!bm) begin
      if (f == 0) begin
        n = 2; w0 = 24'(lo); w1 = 24'(longint'(d) / 65536);
      end else if (f == 3) w0 = 24'(longint'(d) / 256);
      else                 w0 = 24'(longint'(d) % 16777216);
    end else begin
      case (f)
        2'd0: w0 = 24'(longint'(d) % 16777216);
        2'd1: w0 = 24'(lo);
        2'd2: w0 = 24'((lo >= 32768) ? lo + 16711680 : lo);
        default: w0 = 24'(lo * 256);
      endcase
    end
  endtask

  task automatic setFmt(input logic bm, input logic [1:0] f);
    @(negedge clk);
    busMode = bm; idleMode = 1'b1; fmtReqValid = 1'b1; fmtReq = f;
    @(negedge clk);
    fmtReqValid = 1'b0;
    chk(hostWrReady == 1'b0, "R11", "ready in apply cycle", hostWrReady, 0);
    @(negedge clk);
    chk(fmtCur == f && fmtApplied, "R11", "code after apply", {fmtApplied, fmtCur}, {1'b1, f});
    @(negedge clk);
    chk(fmtApplied == 1'b0, "R11", "flag is a pulse", fmtApplied, 0);
    idleMode = 1'b0;
  endtask

  task automatic hostWrite(input logic [31:0] d);
    while (!hostWrReady) @(negedge clk);
    hostWrValid = 1'b1; hostWrData = d;
    @(negedge clk);
    hostWrValid = 1'b0;
  endtask

  task automatic popCheck(input logic [23:0] exp, input string req);
    chk(popValid && popData == exp, req, "popped word", {popValid, popData}, {1'b1, exp});
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  initial begin
    logic [31:0] lcg;
    logic [31:0] pats [8];
    logic [23:0] w0, w1;
    int n;
    string tags [2][4];
    tags = '{'{"R1", "R2", "R2", "R3"}, '{"R4", "R5", "R6", "R7"}};

    repeat (3) @(negedge clk);
    chk(popValid == 0, "R8", "popValid in reset", popValid, 0);
    chk(hostWrReady == 1, "R8", "ready in reset", hostWrReady, 1);
    chk(fmtCur == 0 && fmtApplied == 0, "R8", "code in reset", {fmtApplied, fmtCur}, 0);
    rstN = 1'b1;
    @(negedge clk);

    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    chk(popValid == 0 && hostWrReady == 1, "R10", "pop on empty", {popValid, hostWrReady}, 1);

    lcg = 32'h1357_9BDF;
    pats[0] = 32'h0000_8000; pats[1] = 32'hFFFF_7FFF;
    pats[2] = 32'h1234_5678; pats[3] = 32'h80FF_00A5;
    for (int i = 4; i < 8; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pats[i] = lcg;
    end

    for (int bm = 0; bm < 2; bm++) begin
      for (int f = 0; f < 4; f++) begin
        setFmt(1'(bm), 2'(f));
        for (int p = 0; p < 8; p++) begin
          hostWrite(pats[p]);
          expWords(1'(bm), 2'(f), pats[p], n, w0, w1);
          popCheck(w0, tags[bm][f]);
          if (n == 2) popCheck(w1, tags[bm][f]);
          chk(popValid == 0, tags[bm][f], "word count", popValid, 0);
        end
      end
    end

    setFmt(1'b0, 2'd1);
    for (int i = 0; i < 3; i++) hostWrite(32'h0011_1100 * (i + 1));
    chk(hostWrReady == 1, "R9", "one free single", hostWrReady, 1);
    hostWrite(32'h00AB_CDEF);
    chk(hostWrReady == 0, "R9", "full single", hostWrReady, 0);
    for (int i = 0; i < 3; i++) popCheck(24'(32'h0011_1100 * (i + 1)), "R10");
    popCheck(24'hABCDEF, "R10");

    setFmt(1'b0, 2'd0);
    hostWrite(32'hA1A2_B1B2);
    chk(hostWrReady == 1, "R9", "two free split", hostWrReady, 1);
    hostWrite(32'hC1C2_D1D2);
    chk(hostWrReady == 0, "R9", "full split", hostWrReady, 0);
    popCheck(24'h00B1B2, "R1");
    chk(hostWrReady == 0, "R9", "one free split", hostWrReady, 0);
    popCheck(24'h00A1A2, "R1");
    chk(hostWrReady == 1, "R9", "two free after pops", hostWrReady, 1);
    popCheck(24'h00D1D2, "R10");
    popCheck(24'h00C1C2, "R10");

    setFmt(1'b1, 2'd1);
    hostWrite(32'h0000_9ABC);
    @(negedge clk);
    fmtReqValid = 1'b1; fmtReq = 2'd2;
    @(negedge clk);
    fmtReqValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(fmtCur == 1 && !fmtApplied, "R11", "held while queued", {fmtApplied, fmtCur}, 1);
      @(negedge clk);
    end
    popCheck(24'h009ABC, "R11");
    chk(hostWrReady == 0, "R11", "ready in apply cycle", hostWrReady, 0);
    @(negedge clk);
    chk(fmtCur == 2 && fmtApplied, "R11", "applied after drain", {fmtApplied, fmtCur}, 6);
    hostWrite(32'h0000_9ABC);
    popCheck(24'hFF9ABC, "R6");

    setFmt(1'b0, 2'd1);
    @(negedge clk);
    fmtReqValid = 1'b1; fmtReq = 2'd0;
    @(negedge clk);
    fmtReqValid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(fmtCur == 1 && !fmtApplied && hostWrReady, "R12", "held without idle",
          {hostWrReady, fmtApplied, fmtCur}, 9);
      @(negedge clk);
    end
    idleMode = 1'b1;
    @(negedge clk);
    chk(fmtCur == 0 && fmtApplied, "R12", "applied on idle", {fmtApplied, fmtCur}, 4);
    idleMode = 1'b0;
    hostWrite(32'hDEAD_BEEF);
    popCheck(24'h00BEEF, "R1");
    popCheck(24'h00DEAD, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule